// File: doc/BRIEF.md
# Conversion Timing and Data-Ready Controller

This block derives all conversion timing of an oversampling converter from one master clock. A single phase counter runs over one output-data period and yields a modulator-rate enable, an output-data-period event and a load pulse for the 24-bit result register kept outside the block. The period length comes from a one-bit speed select and a two-bit rate field. The active-low data-ready flag (`drdy_n`) is raised for a guard window ahead of every register update and falls once a fresh word has been loaded. A completed read raises it again.

Command strobes act on the counter. A sync request restarts the period. A short calibration (offset-only or gain-only) lasts two data periods and a full calibration lasts four. The end of a calibration is signalled by a data-ready fall, and the conversion that follows is withheld. Sleep freezes the counter with data-ready high, and wakeup starts a fresh full period. Filtering and calibration arithmetic live elsewhere.

Top module: `conv_timer`

## Requirements
- R1: While `rst_n` is low, `drdy_n` is 1 and `load_pulse` and `cal_busy` are 0.
- R2: With period length L = (FRAME_MODS << MOD_LOG2) << (speed_sel + rate), `period_tick` and `load_pulse` are high for one cycle every L cycles. The first such cycle is cycle L-1 after reset release, counting the first cycle with `rst_n` high as cycle 0.
- R3: `mod_tick` pulses once every (1 << MOD_LOG2) << speed_sel cycles.
- R4: A `rate_sel` value of 3 gives the same period as the value 2.
- R5: `drdy_n` is 0 in the cycle after a `load_pulse`. It is 1 in the cycle after a `read_done` that does not fall on a period event.
- R6: `drdy_n` is 1 for the GUARD cycles that end with the load cycle, and it is still 0 in the cycle just before those cycles when a result is pending.
- R7: After a `sync_req` in cycle s, the next load falls in cycle s+L.
- R8: `cal_short_req` restarts the period and holds `cal_busy` high for 2 periods with no loads. At the end of those periods `drdy_n` falls without a load, the next period event is withheld with `drdy_n` high, and the period after that loads.
- R9: `cal_full_req` behaves as in R8, but for 4 periods.
- R10: `sleep_req` sets `drdy_n` to 1 and stops `mod_tick` and the period events until `wake_req`. After a wake in cycle w, the next load falls in cycle w+L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 1 | Doubles the modulator divide when 1 |
| rate_sel | input | 2 | Period multiplier exponent (3 treated as 2) |
| sync_req | input | 1 | Restart the conversion period |
| cal_short_req | input | 1 | Start a two-period calibration |
| cal_full_req | input | 1 | Start a four-period calibration |
| sleep_req | input | 1 | Freeze timing, hold data-ready high |
| wake_req | input | 1 | Leave sleep and start a full period |
| read_done | input | 1 | Result register read has completed |
| mod_tick | output | 1 | Modulator-rate enable |
| period_tick | output | 1 | Output-data-period event |
| load_pulse | output | 1 | Load the result register |
| drdy_n | output | 1 | Data ready, active low |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The load pulse and the period event are combinational from the phase counter. They appear in cycle L-1 after reset, and in the L-th cycle after a sync, a calibration start or a wake, when that cycle is counted as cycle 0. `drdy_n` and `cal_busy` are registered and change one cycle after the event that moves them. The bench numbers every cycle from reset release. A driver queues the cycle numbers at which loads are due, and a monitor compares each observed load against the head of the queue. Level checks on `drdy_n`, `cal_busy` and the tick counts are sampled at the falling clock edge of the exact cycle derived above, including the last cycle before the guard and the first cycle after it.

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int MOD_LOG2   = 7,
  parameter int FRAME_MODS = 1280,
  parameter int GUARD      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_sel,
  input  logic [1:0] rate_sel,
  input  logic       sync_req,
  input  logic       cal_short_req,
  input  logic       cal_full_req,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       read_done,
  output logic       mod_tick,
  output logic       period_tick,
  output logic       load_pulse,
  output logic       drdy_n,
  output logic       cal_busy
);
  localparam int MOD_LEN  = 1 << MOD_LOG2;
  localparam int BASE_LEN = FRAME_MODS * MOD_LEN;
  localparam int CW       = $clog2(BASE_LEN * 8) + 1;

  logic [CW-1:0] ph, plen, mmask;
  logic [2:0]    shamt, cal_left;
  logic [1:0]    dr_eff;
  logic          asleep, discard, last, guard;

  assign dr_eff = (rate_sel == 2'd3) ? 2'd2 : rate_sel;
  assign shamt  = {1'b0, dr_eff} + {2'b00, speed_sel};
  assign plen   = CW'(BASE_LEN) << shamt;
  assign mmask  = (CW'(MOD_LEN) << speed_sel) - CW'(1);
  assign last   = ph >= plen - CW'(1);
  assign guard  = (ph + CW'(GUARD + 1)) >= plen;

  assign mod_tick    = !asleep && ((ph & mmask) == mmask);
  assign period_tick = !asleep && last;
  assign load_pulse  = period_tick && (cal_left == 3'd0) && !discard;
  assign cal_busy    = cal_left != 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= '0;
      asleep   <= 1'b0;
      cal_left <= 3'd0;
      discard  <= 1'b0;
      drdy_n   <= 1'b1;
    end else if (asleep) begin
      if (wake_req) begin
        asleep <= 1'b0;
        ph     <= '0;
      end
    end else if (sleep_req) begin
      asleep <= 1'b1;
      drdy_n <= 1'b1;
    end else if (cal_full_req || cal_short_req) begin
      cal_left <= cal_full_req ? 3'd4 : 3'd2;
      ph       <= '0;
      discard  <= 1'b0;
      drdy_n   <= 1'b1;
    end else begin
      ph <= (last || sync_req) ? '0 : ph + CW'(1);
      if (last) begin
        if (cal_left == 3'd1) begin
          cal_left <= 3'd0;
          discard  <= 1'b1;
          drdy_n   <= 1'b0;
        end else if (cal_left != 3'd0) begin
          cal_left <= cal_left - 3'd1;
          drdy_n   <= 1'b1;
        end else if (discard) begin
          discard <= 1'b0;
          drdy_n  <= 1'b1;
        end else begin
          drdy_n <= 1'b0;
        end
      end else if (guard || read_done) begin
        drdy_n <= 1'b1;
      end
    end
  end

  a_r5_load_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !sleep_req && !cal_short_req && !cal_full_req) |=> !drdy_n);

  a_r5_read_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !period_tick) |=> drdy_n);

  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> ($past(load_pulse) || $past(cal_busy)));

  a_r9_cal_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_full_req && !asleep && !sleep_req) |=> cal_busy);

  a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !asleep) |=> (drdy_n && !mod_tick && !period_tick));
endmodule

// File: tb/tb_conv_timer.sv
module tb_conv_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_sel = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic sync_req = 1'b0, cal_short_req = 1'b0, cal_full_req = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, read_done = 1'b0;
  logic mod_tick, period_tick, load_pulse, drdy_n, cal_busy;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  int ticks = 0;
  int exp_q[$];
  string cur_req = "R2";
  bit done = 1'b0;

  always #5 clk = ~clk;

  conv_timer #(.MOD_LOG2(2), .FRAME_MODS(5), .GUARD(4)) dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .rate_sel(rate_sel),
    .sync_req(sync_req), .cal_short_req(cal_short_req), .cal_full_req(cal_full_req),
    .sleep_req(sleep_req), .wake_req(wake_req), .read_done(read_done),
    .mod_tick(mod_tick), .period_tick(period_tick), .load_pulse(load_pulse),
    .drdy_n(drdy_n), .cal_busy(cal_busy));

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (rst_n && mod_tick) ticks++;
    if (rst_n && load_pulse) begin
      nvec++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL %s: load in cycle %0d, expected none", cur_req, cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          nfail++;
          $display("FAIL %s: load in cycle %0d, expected %0d", cur_req, cyc, e);
        end
      end
    end
  end

  task automatic expect_load(input int w);
    exp_q.push_back(w);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_win(input int w);
    while (cyc != w) @(negedge clk);
  endtask

  task automatic restart(input logic sp, input logic [1:0] rt, input string req);
    @(negedge clk);
    rst_n = 1'b0;
    speed_sel = sp;
    rate_sel = rt;
    @(negedge clk);
    // R1: reset state
    chk("R1", drdy_n, 1);
    chk("R1", load_pulse, 0);
    chk("R1", cal_busy, 0);
    @(negedge clk);
    exp_q.delete();
    cur_req = req;
    ticks = 0;
    rst_n = 1'b1;
  endtask

  task automatic finish_scn();
    nvec++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL %s: load missing, expected in cycle %0d, got none", cur_req, exp_q[0]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    // R2, R3, R5, R6: base period of 20 cycles
    restart(1'b0, 2'd0, "R2");
    expect_load(19); expect_load(39); expect_load(59); expect_load(79);
    wait_win(25); chk("R5", drdy_n, 0);
    wait_win(35); chk("R6", drdy_n, 0);
    wait_win(36); chk("R6", drdy_n, 1);
    wait_win(40); chk("R5", drdy_n, 0);
    wait_win(45); read_done = 1'b1;
    @(negedge clk); read_done = 1'b0;
    chk("R5", drdy_n, 1);
    wait_win(80); chk("R3", ticks, 20);
    finish_scn();

    // R2, R3: speed select doubles both divides
    restart(1'b1, 2'd0, "R2");
    expect_load(39); expect_load(79);
    wait_win(80); chk("R3", ticks, 10);
    finish_scn();

    // R4: rate 3 same as rate 2 (period 80)
    restart(1'b0, 2'd3, "R4");
    expect_load(79); expect_load(159);
    wait_win(160);
    finish_scn();

    // R7: sync realigns the period
    restart(1'b0, 2'd0, "R7");
    expect_load(19); expect_load(50); expect_load(70);
    wait_win(30); sync_req = 1'b1;
    @(negedge clk); sync_req = 1'b0;
    wait_win(75);
    finish_scn();

    // R8: short calibration, two periods then one discarded result
    restart(1'b0, 2'd0, "R8");
    expect_load(19); expect_load(105);
    wait_win(25); cal_short_req = 1'b1;
    @(negedge clk); cal_short_req = 1'b0;
    chk("R8", cal_busy, 1); chk("R8", drdy_n, 1);
    wait_win(65); chk("R8", cal_busy, 1);
    wait_win(66); chk("R8", cal_busy, 0); chk("R8", drdy_n, 0);
    wait_win(86); chk("R8", drdy_n, 1);
    wait_win(106); chk("R8", drdy_n, 0);
    wait_win(110);
    finish_scn();

    // R9: full calibration, four periods
    restart(1'b0, 2'd0, "R9");
    expect_load(19); expect_load(145);
    wait_win(25); cal_full_req = 1'b1;
    @(negedge clk); cal_full_req = 1'b0;
    wait_win(105); chk("R9", cal_busy, 1);
    wait_win(106); chk("R9", cal_busy, 0); chk("R9", drdy_n, 0);
    wait_win(126); chk("R9", drdy_n, 1);
    wait_win(146); chk("R9", drdy_n, 0);
    wait_win(150);
    finish_scn();

    // R10: sleep freezes timing, wake restarts a full period
    restart(1'b0, 2'd0, "R10");
    expect_load(19); expect_load(80);
    wait_win(25); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R10", drdy_n, 1);
    ticks = 0;
    wait_win(60); chk("R10", ticks, 0);
    wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    wait_win(70); chk("R10", drdy_n, 1);
    wait_win(81); chk("R10", drdy_n, 0);
    finish_scn();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule